// File: doc/BRIEF.md
# Full-Rate Cascaded Moving-Average Filter

This block turns a one-bit delta-sigma stream into a signed multi-bit word without lowering the sample rate. Every modulator clock yields a new filtered sample. A downstream stage that differentiates or otherwise works on a continuous signal therefore sees small per-clock changes, not the coarse steps that follow a decimator.

Three identical moving-sum stages are chained, which gives a third-order sinc response. Each stage holds a delay line as long as its window, `WIN_LEN` samples (default 32, meant for a 20 MHz modulator clock). On every clock it adds the arriving value to a running total and subtracts the value that falls out of the window. Each stage adds log2(`WIN_LEN`) bits to the word width, so the total can never wrap.

A small fill controller has two states:
- `ST_FILL` is entered on reset. It counts clocks.
- `ST_RUN` is reached through the single transition *fill-complete*, taken on the clock that completes 3·`WIN_LEN` clocks. The block stays in `ST_RUN` until the next reset.

Top module: `boxcar3_fullrate`

## Requirements
- R1: The input bit is taken as +1 when `ds_bit` is 1 and as −1 when it is 0. One new output value is produced on every rising clock edge, with no rate reduction.
- R2: Number the rising edges after reset release from 0. Let x(e) be the mapped input at edge e, with x(e) = 0 for e < 0. Then `y` after edge t equals the sum over i of c(i)·x(t−2−i). Here c(i) is the number of triples (j,k,m), each in [0, WIN_LEN), with j+k+m = i.
- R3: `y` is two's complement, 2 + STAGES·log2(WIN_LEN) bits wide (17 by default). It never leaves the range ±WIN_LEN³.
- R4: If `ds_bit` has been 1 on each of the last 3·WIN_LEN edges, `y` equals +WIN_LEN³. If it has been 0 on each of those edges, `y` equals −WIN_LEN³.
- R5: `y_valid` is 0 for the first 3·WIN_LEN−1 edges after reset release. It becomes 1 after edge 3·WIN_LEN−1, which is the fill-complete transition, and it stays 1 until reset.
- R6: While `rst_n` is low, which is asynchronous and active low, `y` is 0 and `y_valid` is 0. All delay lines and sums are cleared, so no sample from before the reset reaches a later output.
- R7: Whenever `y_valid` is 1, `y` is even. It is a sum of an even number of ±1 terms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ds_bit | input | 1 | One-bit delta-sigma stream |
| y | output | 2+STAGES·log2(WIN_LEN) | Filtered signed sample, one per clock |
| y_valid | output | 1 | High once every window holds post-reset data |

## Verification
The bench builds the filter with `WIN_LEN` = 8 and the default three stages. This gives a 22-tap combined response, a 24-clock fill period and a full scale of ±512 in an 11-bit word. With these values the whole impulse response, the exact fill-complete edge and both saturation levels are reached within a few dozen clocks. That leaves room for long random runs at several bit densities and for a reset in the middle of the stream. Every output is compared against a convolution with coefficients that the bench computes from the triple count.

// File: rtl/bx_pkg.sv
package bx_pkg;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } fill_state_t;

    // Output word width: a 2-bit signed input widened by log2(R) per stage.
    function automatic int out_width(input int n_stages, input int win_len);
        return 2 + n_stages * $clog2(win_len);
    endfunction

endpackage

// File: rtl/bx_stage.sv
module bx_stage #(
    parameter int WIN_LEN = 32,
    parameter int IN_W    = 2,
    localparam int OUT_W  = IN_W + $clog2(WIN_LEN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] sum
);

    logic signed [IN_W-1:0]  dly [WIN_LEN];
    logic signed [OUT_W-1:0] sum_q;

    // Delay line: dly[WIN_LEN-1] is the sample leaving the window this clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN_LEN; i++) dly[i] <= '0;
        end else begin
            dly[0] <= din;
            for (int i = 1; i < WIN_LEN; i++) dly[i] <= dly[i-1];
        end
    end

    // Running sum: add the newcomer, drop the oldest.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_q + OUT_W'(din) - OUT_W'(dly[WIN_LEN-1]);
    end

    assign sum = sum_q;

endmodule

// File: rtl/bx_fill_fsm.sv
module bx_fill_fsm #(
    parameter int FILL_LEN = 96,
    localparam int CNT_W   = $clog2(FILL_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    output logic full
);
    import bx_pkg::*;

    fill_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    // Next state: fill-complete on the clock that ends the fill period.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (cnt_q == CNT_W'(FILL_LEN - 1)) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (state_q == ST_FILL) cnt_q <= cnt_q + 1'b1;
    end

    // Output process.
    always_comb begin
        unique case (state_q)
            ST_FILL: full = 1'b0;
            ST_RUN:  full = 1'b1;
            default: full = 1'b0;
        endcase
    end

endmodule

// File: rtl/boxcar3_fullrate.sv
module boxcar3_fullrate #(
    parameter int WIN_LEN = 32,
    parameter int STAGES  = 3,
    localparam int LG     = $clog2(WIN_LEN),
    localparam int Y_W    = bx_pkg::out_width(STAGES, WIN_LEN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ds_bit,
    output logic signed [Y_W-1:0] y,
    output logic                  y_valid
);

    initial begin
        if (WIN_LEN < 2 || (1 << LG) != WIN_LEN)
            $error("WIN_LEN must be a power of two, at least 2");
    end

    // Bit 1 -> +1, bit 0 -> -1.
    logic signed [1:0] x0;
    assign x0 = ds_bit ? 2'sb01 : 2'sb11;

    for (genvar k = 0; k < STAGES; k++) begin : g_st
        localparam int IW = 2 + k * LG;
        localparam int OW = IW + LG;
        logic signed [IW-1:0] s_in;
        logic signed [OW-1:0] s_out;

        if (k == 0) begin : g_src
            assign s_in = x0;
        end else begin : g_src
            assign s_in = g_st[k-1].s_out;
        end

        bx_stage #(
            .WIN_LEN (WIN_LEN),
            .IN_W    (IW)
        ) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (s_in),
            .sum   (s_out)
        );
    end

    assign y = g_st[STAGES-1].s_out;

    bx_fill_fsm #(
        .FILL_LEN (STAGES * WIN_LEN)
    ) u_fill (
        .clk   (clk),
        .rst_n (rst_n),
        .full  (y_valid)
    );

endmodule

// File: rtl/boxcar3_fullrate_chk.sv
module boxcar3_fullrate_chk #(
    parameter int WIN_LEN = 32,
    parameter int STAGES  = 3,
    parameter int Y_W     = 17
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ds_bit,
    input logic signed [Y_W-1:0] y,
    input logic                  y_valid
);
    localparam int FILL = STAGES * WIN_LEN;
    localparam int FULL = WIN_LEN ** STAGES;

    int edge_cnt, ones_run, zeros_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt  <= 0;
            ones_run  <= 0;
            zeros_run <= 0;
        end else begin
            if (edge_cnt < FILL) edge_cnt <= edge_cnt + 1;
            if (ds_bit) begin
                ones_run  <= (ones_run < FILL) ? ones_run + 1 : FILL;
                zeros_run <= 0;
            end else begin
                zeros_run <= (zeros_run < FILL) ? zeros_run + 1 : FILL;
                ones_run  <= 0;
            end
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (y <= FULL) && (y >= -FULL));

    a_r4_pos_full: assert property (@(posedge clk) disable iff (!rst_n)
        (ones_run >= FILL) |-> (y == FULL));

    a_r4_neg_full: assert property (@(posedge clk) disable iff (!rst_n)
        (zeros_run >= FILL) |-> (y == -FULL));

    a_r5_valid_timing: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid == (edge_cnt >= FILL));

    a_r5_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |=> y_valid);

    a_r7_even_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> (y[0] == 1'b0));

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r6_reset_clear: assert (y == '0 && !y_valid);
        end
    end

endmodule

bind boxcar3_fullrate boxcar3_fullrate_chk #(
    .WIN_LEN (WIN_LEN),
    .STAGES  (STAGES),
    .Y_W     (Y_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ds_bit  (ds_bit),
    .y       (y),
    .y_valid (y_valid)
);

// File: tb/tb_boxcar3_fullrate.sv
module tb_boxcar3_fullrate;

    localparam int R    = 8;
    localparam int NST  = 3;
    localparam int YW   = 2 + NST * $clog2(R);
    localparam int FILL = NST * R;
    localparam int FULL = R * R * R;
    localparam int NTAP = NST * R - 2;

    logic clk = 1'b0;
    logic rst_n;
    logic ds_bit;
    logic signed [YW-1:0] y;
    logic y_valid;

    always #2.5 clk = ~clk;

    boxcar3_fullrate #(.WIN_LEN(R), .STAGES(NST)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ds_bit  (ds_bit),
        .y       (y),
        .y_valid (y_valid)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int coef [NTAP];
    int hist [8192];
    int t_idx = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at edge %0d", tag, act, exp, t_idx);
        end
    endtask

    function automatic int exp_y(input int e);
        int acc = 0;
        for (int i = 0; i < NTAP; i++) begin
            int idx = e - 2 - i;
            if (idx >= 0) acc += coef[i] * hist[idx];
        end
        return acc;
    endfunction

    // Called just after a falling edge: checks the previous edge's output,
    // then drives the bit for the coming edge.
    task automatic step(input logic b, input string tag);
        int yi;
        yi = int'(y);
        if (t_idx == 0) begin
            check("R6 y after reset", yi, 0);
            check("R6 valid after reset", int'(y_valid), 0);
        end else begin
            check({tag, " y"}, yi, exp_y(t_idx - 1));
            check("R5 valid", int'(y_valid), int'((t_idx - 1) >= FILL - 1));
            if (yi > FULL || yi < -FULL) check("R3 range", yi, FULL);
            if (y_valid) check("R7 even", yi % 2, 0);
        end
        ds_bit = b;
        hist[t_idx] = b ? 1 : -1;
        @(posedge clk);
        t_idx++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R6 y in reset", int'(y), 0);
        check("R6 valid in reset", int'(y_valid), 0);
        rst_n = 1'b1;
        t_idx = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int sd;
        for (int i = 0; i < NTAP; i++) coef[i] = 0;
        for (int j = 0; j < R; j++)
            for (int k = 0; k < R; k++)
                for (int m = 0; m < R; m++)
                    coef[j + k + m]++;
        sd = $urandom(32'd4711);
        rst_n  = 1'b1;
        ds_bit = 1'b0;
        #1 rst_n = 1'b0;

        // Impulse-like start: single one among zeros shows latency (R2).
        do_reset();
        step(1'b1, "R2 impulse");
        for (int i = 0; i < 40; i++) step(1'b0, "R2 impulse");

        // All ones then all zeros: both full-scale levels (R4).
        do_reset();
        for (int i = 0; i < 3 * FILL; i++) step(1'b1, "R4 ones");
        check("R4 +full", int'(y), FULL);
        for (int i = 0; i < 3 * FILL; i++) step(1'b0, "R4 zeros");
        check("R4 -full", int'(y), -FULL);

        // Alternating bits: mapping symmetry, one output per clock (R1).
        for (int i = 0; i < 4 * FILL; i++) step(logic'(i % 2), "R1 alternate");

        // Random at several densities (R2, R3).
        for (int i = 0; i < 600; i++) step(logic'($urandom_range(1, 0)), "R2 random");
        for (int i = 0; i < 300; i++) step(logic'($urandom_range(9, 0) < 8), "R3 dense");
        for (int i = 0; i < 300; i++) step(logic'($urandom_range(9, 0) < 1), "R3 sparse");

        // Reset mid-stream: old history must not leak (R6).
        do_reset();
        for (int i = 0; i < 500; i++) step(logic'($urandom_range(3, 0) != 0), "R6 restart");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule